// File: doc/BRIEF.md
# Programmable Reset Duration Sequencer

This block is the timing core of a supply supervisor. It drives an active-low system reset and a clock-source selector for an external controller. Reset is pulled low in the cycle after any reset event. After the event's condition has ended, reset is held low for a selectable number of milliseconds and then released. All time is counted on a one-cycle millisecond tick strobe supplied from outside.

The hold time comes from one of two sources. The first is a three-state strap, which chooses a short fixed time, a medium fixed time, or the programmed value. The second is a 5-bit programmed code, which indexes a piecewise-geometric table of durations. Some causes double the hold time. Writing a code whose duration is longer than the current one starts a reset on its own.

Around each reset, the selector gives the controller a short burst of a fixed fallback clock and then turns the clock off. It switches to the programmed clock rate shortly before reset is released. All pins are plain level or strobe controls. The block has no streaming data interface and no back-pressure.

Top module: `rstseq_top`

## Requirements
- R1: After the synchronous active-low reset `rst_ni`, `sys_rst_no` is 0 and `clk_sel_o` is 00 (off). Both keep these values until a reset event occurs.
- R2: A reset event drives `sys_rst_no` low in the next cycle. The events are a rising edge of `cond_i`, a pulse on `bo_evt_i`, `wd_evt_i` or `por_evt_i`, or a longer code load (R11). `sys_rst_no` stays low for as long as `cond_i` is high.
- R3: The duration D is selected by `strap_i` and `alt_mode_i`. `strap_i`=00 gives 6 ms and `strap_i`=01 gives 270 ms. `strap_i`=10 or 11 uses the table value of the stored code. When `alt_mode_i`=1, the table value is used for every strap setting.
- R4: The table maps code c to a duration in ms. Codes 0..4 give 6·(c+1). Beyond code 4, the codes form groups of four: codes 5–8, 9–12, 13–16, 17–20, 21–24, 25–28, and 29–31 (which has only three codes). Within group g=1..7, each code adds 6·2^g ms to the previous code. Code 8 is 78 ms and code 31 is 5358 ms.
- R5: Countdown begins in the cycle after the event's condition ends. For pulse events, that is the cycle after the pulse. Each later tick adds one. `sys_rst_no` goes high in the cycle after the tick on which the count reaches the target, so it only rises right after a tick.
- R6: An event on `bo_evt_i` or `wd_evt_i` sets the target to 2·D.
- R7: An event on `por_evt_i` sets the target to D.
- R8: Every event sets `clk_sel_o` to 01 (fallback) in the next cycle, unless `vdd_low_i` is high. The selector returns to 00 after 2 ticks. The value 11 never appears.
- R9: When `vdd_low_i` is high during an event, or during the fallback window, `clk_sel_o` becomes 00 in the next cycle.
- R10: On the 4th tick of the countdown, `clk_sel_o` becomes 10 (programmed rate). It therefore reads 10 when reset is released.
- R11: A pulse on `code_load_i` stores `code_i`. If the table value of the new code is greater than that of the stored code, it also counts as an event with target D. A code that is not longer leaves `sys_rst_no` high.
- R12: A new event while reset is held restarts the countdown from zero. The doubling rule of the new cause applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| ms_tick_i | input | 1 | One-cycle millisecond strobe |
| cond_i | input | 1 | Reset-condition level |
| bo_evt_i | input | 1 | Brownout event pulse |
| wd_evt_i | input | 1 | Watchdog timeout/violation pulse |
| por_evt_i | input | 1 | Power-up event pulse |
| vdd_low_i | input | 1 | Supply below the clock-stop threshold |
| strap_i | input | 2 | Strap code: 00 low, 01 floating, 10/11 high |
| alt_mode_i | input | 1 | Non-standard mode, forces the table |
| code_i | input | 5 | Duration code to load |
| code_load_i | input | 1 | Load strobe for `code_i` |
| sys_rst_no | output | 1 | Active-low system reset |
| clk_sel_o | output | 2 | 00 off, 01 fallback, 10 programmed |

## Verification
The hardest cases to reach are the ones that collide in time: a second event of a different cause arriving part-way through a doubled countdown, and the supply-low flag rising inside the two-tick fallback window. The stimulus reaches them by firing pulses a known number of ticks after an earlier event. A behavioural model tracks every cycle alongside the design. The full table is covered by loading codes in ascending order in the non-standard mode, so each load is longer than the last and starts its own measured reset.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [1:0] {
    CS_OFF      = 2'b00,
    CS_FALLBACK = 2'b01,
    CS_PROG     = 2'b10
  } clk_sel_e;

  typedef enum logic [1:0] {
    PH_PARK,
    PH_HOLD,
    PH_COUNT,
    PH_IDLE
  } phase_e;

  typedef enum logic [1:0] {
    STRAP_LOW   = 2'b00,
    STRAP_FLOAT = 2'b01,
    STRAP_HIGH  = 2'b10,
    STRAP_HIGH2 = 2'b11
  } strap_e;

endpackage

// File: rtl/rstseq_dur_lut.sv
module rstseq_dur_lut #(
  parameter int unsigned CODE_W    = 5,
  parameter int unsigned DUR_W     = 13,
  parameter int unsigned UNIT_MS   = 6,
  parameter int unsigned LIN_CODES = 5,
  parameter int unsigned GRP_LOG2  = 2
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [DUR_W-1:0]  dur_o
);

  localparam int unsigned LIN_END  = UNIT_MS * LIN_CODES;
  localparam int unsigned GRP_STEP = UNIT_MS << GRP_LOG2;

  logic [CODE_W-1:0]   off;
  logic [CODE_W-1:0]   grp;
  logic [GRP_LOG2:0]   pos;

  // linear run first, then groups whose step doubles each time
  always_comb begin
    off = code_i - CODE_W'(LIN_CODES);
    grp = (off >> GRP_LOG2) + CODE_W'(1);
    pos = {1'b0, off[GRP_LOG2-1:0]} + (GRP_LOG2+1)'(1);
    if (code_i < CODE_W'(LIN_CODES)) begin
      dur_o = DUR_W'(UNIT_MS) * (DUR_W'(code_i) + DUR_W'(1));
    end else begin
      dur_o = DUR_W'(LIN_END)
            + DUR_W'(GRP_STEP) * ((DUR_W'(1) << grp) - DUR_W'(2))
            + DUR_W'(pos) * (DUR_W'(UNIT_MS) << grp);
    end
  end

endmodule

// File: rtl/rstseq_dur_sel.sv
module rstseq_dur_sel
  import rstseq_pkg::*;
#(
  parameter int unsigned CODE_W   = 5,
  parameter int unsigned DUR_W    = 13,
  parameter int unsigned SHORT_MS = 6,
  parameter int unsigned MID_MS   = 270,
  parameter int unsigned CODE_RST = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        strap_i,
  input  logic              alt_mode_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              load_i,
  output logic [DUR_W-1:0]  eff_ms_o,
  output logic              load_longer_o
);

  localparam int unsigned N_LOOKUP = 2;  // stored code, incoming code

  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] lk_code [N_LOOKUP];
  logic [DUR_W-1:0]  lk_dur  [N_LOOKUP];

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     code_q <= CODE_W'(CODE_RST);
    else if (load_i) code_q <= code_i;
  end

  assign lk_code[0] = code_q;
  assign lk_code[1] = code_i;

  for (genvar gi = 0; gi < N_LOOKUP; gi++) begin : g_lut
    rstseq_dur_lut #(
      .CODE_W (CODE_W),
      .DUR_W  (DUR_W)
    ) i_lut (
      .code_i (lk_code[gi]),
      .dur_o  (lk_dur[gi])
    );
  end

  assign load_longer_o = load_i && (lk_dur[1] > lk_dur[0]);

  always_comb begin
    if (alt_mode_i) begin
      eff_ms_o = lk_dur[0];
    end else begin
      unique case (strap_e'(strap_i))
        STRAP_LOW:   eff_ms_o = DUR_W'(SHORT_MS);
        STRAP_FLOAT: eff_ms_o = DUR_W'(MID_MS);
        default:     eff_ms_o = lk_dur[0];
      endcase
    end
  end

endmodule

// File: rtl/rstseq_core.sv
module rstseq_core
  import rstseq_pkg::*;
#(
  parameter int unsigned DUR_W   = 13,
  parameter int unsigned PROG_MS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cond_i,
  input  logic             bo_i,
  input  logic             wd_i,
  input  logic             por_i,
  input  logic             load_trig_i,
  input  logic [DUR_W-1:0] eff_ms_i,
  output logic             sys_rst_no,
  output logic             evt_o,
  output logic             prog_pt_o
);

  localparam int unsigned CNT_W = DUR_W + 1;  // room for a doubled target

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] tgt;
  logic             dbl_q;
  logic             cond_q;
  logic             rst_q;
  logic             step;

  assign evt_o   = (cond_i && !cond_q) || bo_i || wd_i || por_i || load_trig_i;
  assign tgt     = dbl_q ? {eff_ms_i, 1'b0} : {1'b0, eff_ms_i};
  assign cnt_nxt = cnt_q + CNT_W'(1);
  assign step    = !evt_o && (ph_q == PH_COUNT) && tick_i;
  assign prog_pt_o = step && (cnt_nxt == CNT_W'(PROG_MS));
  assign sys_rst_no = rst_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ph_q   <= PH_PARK;
      cnt_q  <= '0;
      dbl_q  <= 1'b0;
      cond_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      cond_q <= cond_i;
      if (evt_o) begin
        rst_q <= 1'b0;
        ph_q  <= cond_i ? PH_HOLD : PH_COUNT;
        cnt_q <= '0;
        dbl_q <= bo_i || wd_i;
      end else if (ph_q == PH_HOLD && !cond_i) begin
        ph_q  <= PH_COUNT;
        cnt_q <= '0;
      end else if (step) begin
        cnt_q <= cnt_nxt;
        if (cnt_nxt >= tgt) begin
          rst_q <= 1'b1;
          ph_q  <= PH_IDLE;
        end
      end
    end
  end

endmodule

// File: rtl/rstseq_clk_seq.sv
module rstseq_clk_seq
  import rstseq_pkg::*;
#(
  parameter int unsigned FB_MS = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       evt_i,
  input  logic       vdd_low_i,
  input  logic       prog_pt_i,
  output logic [1:0] clk_sel_o
);

  localparam int unsigned FB_W = $clog2(FB_MS + 1);

  clk_sel_e        sel_q;
  logic [FB_W-1:0] fb_q;

  assign clk_sel_o = sel_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sel_q <= CS_OFF;
      fb_q  <= '0;
    end else if (evt_i) begin
      sel_q <= vdd_low_i ? CS_OFF : CS_FALLBACK;
      fb_q  <= '0;
    end else if (prog_pt_i) begin
      sel_q <= CS_PROG;
    end else if (sel_q == CS_FALLBACK) begin
      if (vdd_low_i) begin
        sel_q <= CS_OFF;
      end else if (tick_i) begin
        fb_q <= fb_q + FB_W'(1);
        if (fb_q + FB_W'(1) == FB_W'(FB_MS)) sel_q <= CS_OFF;
      end
    end
  end

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top #(
  parameter int unsigned CODE_W         = 5,
  parameter int unsigned DUR_W          = 13,
  parameter int unsigned STRAP_SHORT_MS = 6,
  parameter int unsigned STRAP_MID_MS   = 270,
  parameter int unsigned FALLBACK_MS    = 2,
  parameter int unsigned PROG_START_MS  = 4,
  parameter int unsigned CODE_RST       = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ms_tick_i,
  input  logic              cond_i,
  input  logic              bo_evt_i,
  input  logic              wd_evt_i,
  input  logic              por_evt_i,
  input  logic              vdd_low_i,
  input  logic [1:0]        strap_i,
  input  logic              alt_mode_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              code_load_i,
  output logic              sys_rst_no,
  output logic [1:0]        clk_sel_o
);

  logic [DUR_W-1:0] eff_ms;
  logic             load_longer;
  logic             evt;
  logic             prog_pt;

  rstseq_dur_sel #(
    .CODE_W   (CODE_W),
    .DUR_W    (DUR_W),
    .SHORT_MS (STRAP_SHORT_MS),
    .MID_MS   (STRAP_MID_MS),
    .CODE_RST (CODE_RST)
  ) i_sel (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .strap_i       (strap_i),
    .alt_mode_i    (alt_mode_i),
    .code_i        (code_i),
    .load_i        (code_load_i),
    .eff_ms_o      (eff_ms),
    .load_longer_o (load_longer)
  );

  rstseq_core #(
    .DUR_W   (DUR_W),
    .PROG_MS (PROG_START_MS)
  ) i_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (ms_tick_i),
    .cond_i      (cond_i),
    .bo_i        (bo_evt_i),
    .wd_i        (wd_evt_i),
    .por_i       (por_evt_i),
    .load_trig_i (load_longer),
    .eff_ms_i    (eff_ms),
    .sys_rst_no  (sys_rst_no),
    .evt_o       (evt),
    .prog_pt_o   (prog_pt)
  );

  rstseq_clk_seq #(
    .FB_MS (FALLBACK_MS)
  ) i_clk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (ms_tick_i),
    .evt_i     (evt),
    .vdd_low_i (vdd_low_i),
    .prog_pt_i (prog_pt),
    .clk_sel_o (clk_sel_o)
  );

endmodule

// File: rtl/rstseq_chk.sv
module rstseq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ms_tick_i,
  input logic       cond_i,
  input logic       bo_evt_i,
  input logic       wd_evt_i,
  input logic       por_evt_i,
  input logic       vdd_low_i,
  input logic       code_load_i,
  input logic       sys_rst_no,
  input logic [1:0] clk_sel_o
);

  // R2: condition level keeps reset low
  a_r2_cond_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_i |=> !sys_rst_no);

  // R6: watchdog pulse asserts reset
  a_r6_wd_asserts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_evt_i |=> !sys_rst_no);

  // R5: release only follows a tick
  a_r5_release_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no) |-> $past(ms_tick_i));

  // R10: programmed clock already running at release
  a_r10_prog_at_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_no) |-> clk_sel_o == 2'b10);

  // R8: pulse event with healthy supply starts fallback clock
  a_r8_fallback_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bo_evt_i || wd_evt_i || por_evt_i) && !vdd_low_i) |=> clk_sel_o == 2'b01);

  // R8: unused selector encoding never driven
  a_r8_legal_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_sel_o != 2'b11);

  // R9: low supply inside fallback window stops the clock
  a_r9_vdd_low_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_sel_o == 2'b01 && vdd_low_i && !cond_i && !bo_evt_i && !wd_evt_i
     && !por_evt_i && !code_load_i) |=> clk_sel_o == 2'b00);

endmodule

bind rstseq_top rstseq_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ms_tick_i   (ms_tick_i),
  .cond_i      (cond_i),
  .bo_evt_i    (bo_evt_i),
  .wd_evt_i    (wd_evt_i),
  .por_evt_i   (por_evt_i),
  .vdd_low_i   (vdd_low_i),
  .code_load_i (code_load_i),
  .sys_rst_no  (sys_rst_no),
  .clk_sel_o   (clk_sel_o)
);

// File: tb/test_rstseq_top.sv
`timescale 1ns/1ps
module test_rstseq_top;

  localparam int TICK_EVERY = 2;
  localparam int WD_LIMIT   = 190000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ms_tick_i = 1'b0;
  logic       cond_i = 1'b0, bo_evt_i = 1'b0, wd_evt_i = 1'b0, por_evt_i = 1'b0;
  logic       vdd_low_i = 1'b0;
  logic [1:0] strap_i = 2'b00;
  logic       alt_mode_i = 1'b0;
  logic [4:0] code_i = 5'd0;
  logic       code_load_i = 1'b0;
  logic       sys_rst_no;
  logic [1:0] clk_sel_o;

  rstseq_top i_rstseq_top (
    .clk_i(clk), .rst_ni(rst_ni), .ms_tick_i(ms_tick_i), .cond_i(cond_i),
    .bo_evt_i(bo_evt_i), .wd_evt_i(wd_evt_i), .por_evt_i(por_evt_i),
    .vdd_low_i(vdd_low_i), .strap_i(strap_i), .alt_mode_i(alt_mode_i),
    .code_i(code_i), .code_load_i(code_load_i),
    .sys_rst_no(sys_rst_no), .clk_sel_o(clk_sel_o)
  );

  always #10 clk = ~clk;  // 50 MHz

  int errors = 0, checks = 0, cycles = 0, tick_div = 0;
  string cur_req = "R1";
  bit done = 0;

  int tbl [32] = '{6, 12, 18, 24, 30, 42, 54, 66, 78, 102, 126, 150, 174, 222,
                   270, 318, 366, 462, 558, 654, 750, 942, 1134, 1326, 1518,
                   1902, 2286, 2670, 3054, 3822, 4590, 5358};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // millisecond strobe
  always @(negedge clk) begin
    ms_tick_i <= (tick_div == TICK_EVERY - 1);
    tick_div  <= (tick_div == TICK_EVERY - 1) ? 0 : tick_div + 1;
  end

  // behavioural reference model
  int m_rst, m_clk, m_ph, m_cnt, m_dbl, m_fb, m_code, m_condq;
  bit m_valid = 0;
  always @(posedge clk) begin
    int eff, tgt;
    bit trig, evt, prog;
    cycles++;
    if (!rst_ni) begin
      m_rst = 0; m_clk = 0; m_ph = 0; m_cnt = 0; m_dbl = 0; m_fb = 0;
      m_code = 0; m_condq = 0; m_valid = 1;
    end else begin
      eff  = (alt_mode_i || strap_i >= 2) ? tbl[m_code] : (strap_i == 0 ? 6 : 270);
      tgt  = m_dbl ? 2 * eff : eff;
      trig = code_load_i && (tbl[code_i] > tbl[m_code]);
      evt  = (cond_i && !m_condq) || bo_evt_i || wd_evt_i || por_evt_i || trig;
      prog = 0;
      if (evt) begin
        m_rst = 0; m_ph = cond_i ? 1 : 2; m_cnt = 0;
        m_dbl = (bo_evt_i || wd_evt_i) ? 1 : 0;
        m_clk = vdd_low_i ? 0 : 1; m_fb = 0;
      end else begin
        if (m_ph == 1 && !cond_i) begin
          m_ph = 2; m_cnt = 0;
        end else if (m_ph == 2 && ms_tick_i) begin
          m_cnt++;
          if (m_cnt == 4) prog = 1;
          if (m_cnt >= tgt) begin m_rst = 1; m_ph = 3; end
        end
        if (prog) m_clk = 2;
        else if (m_clk == 1) begin
          if (vdd_low_i) m_clk = 0;
          else if (ms_tick_i) begin m_fb++; if (m_fb == 2) m_clk = 0; end
        end
      end
      if (code_load_i) m_code = int'(code_i);
      m_condq = cond_i;
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (m_valid && !done) begin
      check(sys_rst_no == m_rst[0], cur_req, "reset output vs model", sys_rst_no, m_rst);
      check(int'(clk_sel_o) == m_clk, cur_req, "clock select vs model", clk_sel_o, m_clk);
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cycles > WD_LIMIT && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WD_LIMIT);
      finish_run();
    end
  end

  // kind: 0 por, 1 wd, 2 bo, 3 load
  task automatic fire(input int kind, input int code);
    @(negedge clk);
    case (kind)
      0: por_evt_i = 1;
      1: wd_evt_i = 1;
      2: bo_evt_i = 1;
      default: begin code_i = 5'(code); code_load_i = 1; end
    endcase
    @(negedge clk);
    por_evt_i = 0; wd_evt_i = 0; bo_evt_i = 0; code_load_i = 0;
  endtask

  // counts ticks consumed after the event edge up to the release edge
  task automatic measure(input string req, input int exp, output int ticks, output int prog_at);
    bit t;
    ticks = 0; prog_at = -1;
    check(sys_rst_no == 1'b0, req, "asserted after event", sys_rst_no, 0);
    for (int i = 0; i < 30000; i++) begin
      @(posedge clk) t = ms_tick_i;
      @(negedge clk);
      if (t) ticks++;
      if (clk_sel_o == 2'b10 && prog_at < 0) prog_at = ticks;
      if (sys_rst_no) break;
    end
    check(ticks == exp, req, "hold ticks", ticks, exp);
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int tk, pa;
    wait_cycles(4);
    cur_req = "R1";
    check(sys_rst_no == 1'b0, "R1", "reset value of output", sys_rst_no, 0);
    check(clk_sel_o == 2'b00, "R1", "reset clock select", clk_sel_o, 0);
    rst_ni = 1;
    wait_cycles(20);
    check(sys_rst_no == 1'b0, "R1", "held until first event", sys_rst_no, 0);

    // R7 + R3 strap low, R8 fallback, R10 prog point
    cur_req = "R7";
    strap_i = 2'b00;
    fire(0, 0);
    check(clk_sel_o == 2'b01, "R8", "fallback after event", clk_sel_o, 1);
    measure("R7", 6, tk, pa);
    check(pa == 4, "R10", "programmed clock tick", pa, 4);

    // R6 watchdog doubling, R3 floating strap
    cur_req = "R6";
    strap_i = 2'b01;
    fire(1, 0);
    measure("R6", 540, tk, pa);

    // R11 longer load triggers, R3 strap high
    cur_req = "R11";
    strap_i = 2'b10;
    fire(3, 3);
    measure("R11", 24, tk, pa);
    cur_req = "R6";
    fire(2, 0);
    measure("R6", 48, tk, pa);
    cur_req = "R11";
    fire(3, 1);
    wait_cycles(30);
    check(sys_rst_no == 1'b1, "R11", "shorter code leaves reset high", sys_rst_no, 1);
    cur_req = "R3";
    strap_i = 2'b11;
    fire(0, 0);
    measure("R3", 12, tk, pa);
    strap_i = 2'b00; alt_mode_i = 1;
    fire(0, 0);
    measure("R3", 12, tk, pa);

    // R9 supply low at event and inside window
    cur_req = "R9";
    vdd_low_i = 1;
    fire(1, 0);
    check(clk_sel_o == 2'b00, "R9", "clock off at low supply event", clk_sel_o, 0);
    vdd_low_i = 0;
    wait_cycles(60);
    fire(1, 0);
    check(clk_sel_o == 2'b01, "R9", "fallback before supply drop", clk_sel_o, 1);
    vdd_low_i = 1;
    @(negedge clk);
    check(clk_sel_o == 2'b00, "R9", "clock stops in window", clk_sel_o, 0);
    vdd_low_i = 0;
    wait_cycles(60);

    // R12 restart with new cause
    cur_req = "R12";
    fire(2, 0);
    wait_cycles(10);
    fire(0, 0);
    measure("R12", 12, tk, pa);

    // R2 condition level, R5 countdown after condition end
    cur_req = "R2";
    @(negedge clk) cond_i = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(sys_rst_no == 1'b0, "R2", "low while condition high", sys_rst_no, 0);
    end
    cond_i = 0;
    cur_req = "R5";
    wait_cycles(40);
    check(sys_rst_no == 1'b1, "R5", "released after countdown", sys_rst_no, 1);

    // R4 table sweep via ascending loads
    cur_req = "R4";
    fire(3, 0);
    wait_cycles(4);
    for (int c = 1; c < 32; c++) begin
      fire(3, c);
      measure("R4", tbl[c], tk, pa);
    end

    wait_cycles(5);
    done = 1;
    finish_run();
  end

endmodule